// File: doc/BRIEF.md
# Linked-List DMA Channel Sequencer

This block runs one DMA channel. Software loads five 32-bit registers through a simple write port: source address, destination address, next-descriptor pointer, control and configuration. When the channel is enabled and not halted, the sequencer checks the flow mode against the peripheral request lines. Each time the gate opens it moves one element. It reads at the source, writes the same data to the destination, steps the addresses that have increment enabled, and decrements the remaining count held in the control register.

When the count reaches zero the channel either disables itself or reloads its registers from a four-word descriptor in memory. The pointer register selects the descriptor, so a chain of descriptors can carry the channel through several blocks with no software action. All memory traffic uses one valid/ready master port. A one-cycle terminal-count pulse can be requested per block. Flow modes that are not supported, and element formats that are not supported, raise an error flag and nothing is moved.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset every register output (`ch_src`, `ch_dst`, `ch_next`, `ch_ctrl`, `ch_conf`) is zero, and `mem_valid`, `tc_pulse` and `err_flag` are low.
- R2: An element transfer starts only when `ch_conf[0]` (enable) is 1 and `ch_conf[18]` (halt) is 0. A halted or disabled channel issues no memory request.
- R3: The flow mode is `ch_conf[13:11]`, the source peripheral ID is `ch_conf[5:1]` and the destination ID is `ch_conf[10:6]`. The request vector is `req_single | req_burst`. Mode 0 needs no request. Mode 1 needs the destination ID's request bit. Mode 2 needs the source ID's bit. Mode 3 needs both bits.
- R4: The remaining count is `ch_ctrl[11:0]`. An enabled channel with a count of zero makes no transfer and stays enabled.
- R5: One element is a read of width 2^`ch_ctrl[20:18]` bytes at `ch_src`, followed by a write of the read data to `ch_dst`. `mem_size` carries the log2 byte width during both beats and is 2 during descriptor fetches.
- R6: Control bit 26 makes the source address advance by the element width after each read. Control bit 27 does the same for the destination address after each write.
- R7: Each completed element write decrements `ch_ctrl[11:0]` by one. Control bits 31:12 do not change.
- R8: If the count reaches zero while `ch_next` is non-zero, the channel reads four words in this order: +0 into source, +4 into destination, +12 into control, then +8 into the pointer. It then resumes under the new contents.
- R9: If the count reaches zero while `ch_next` is zero, `ch_conf[0]` is cleared.
- R10: When an element takes the count to zero and that block's `ch_ctrl[31]` is set, `tc_pulse` is high for exactly one cycle.
- R11: An enabled, unhalted channel raises `err_flag` and moves nothing if its flow mode is 4 to 7 or if its source and destination widths differ or exceed 4 bytes. Any register write clears the flag.
- R12: Once `mem_valid` is raised, `mem_valid`, `mem_write` and `mem_addr` hold until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 source, 1 destination, 2 pointer, 3 control, 4 configuration |
| reg_wdata | input | 32 | Register write data |
| req_single | input | NREQ | Single request lines from peripherals |
| req_burst | input | NREQ | Burst request lines from peripherals |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 for write beat, 0 for read beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_size | output | 2 | log2 of beat byte width |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |
| ch_src | output | 32 | Current source address |
| ch_dst | output | 32 | Current destination address |
| ch_next | output | 32 | Current next-descriptor pointer |
| ch_ctrl | output | 32 | Current control word |
| ch_conf | output | 32 | Current configuration word |
| tc_pulse | output | 1 | Terminal-count pulse |
| err_flag | output | 1 | Unsupported mode or format seen |

## Verification
The hardest situation to reach is a chain reload that follows a block whose interrupt bit differs from the next block's bit. The pointer fetch must also come last, so that it does not corrupt the addresses of the other three words. The stimulus builds a two-descriptor chain in the bench memory, with the interrupt bit set on the first and last blocks only. It then checks the exact order of the fetch addresses, the final register contents and a pulse count of two, while the memory stalls ready on a fixed rotating pattern. The request gate is swept over every supported mode and every combination of source and destination request, once through the single lines and once through the burst lines.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned CNT_W    = 12;
    // configuration field positions
    localparam int unsigned CF_EN    = 0;
    localparam int unsigned CF_SID   = 1;
    localparam int unsigned CF_DID   = 6;
    localparam int unsigned CF_MODE  = 11;
    localparam int unsigned CF_HALT  = 18;
    // control field positions
    localparam int unsigned CT_SW    = 18;
    localparam int unsigned CT_DW    = 21;
    localparam int unsigned CT_SINC  = 26;
    localparam int unsigned CT_DINC  = 27;
    localparam int unsigned CT_TC    = 31;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD, ST_WR, ST_FSRC, ST_FDST, ST_FCTL, ST_FNXT
    } seq_state_t;

    typedef struct packed {
        seq_state_t        st;
        logic [REG_W-1:0]  src;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  nxt;
        logic [REG_W-1:0]  ctrl;
        logic [REG_W-1:0]  conf;
        logic [REG_W-1:0]  data;
        logic              tc;
        logic              err;
    } seq_regs_t;
endpackage

// File: rtl/dma_req_gate.sv
`timescale 1ns/1ps
module dma_req_gate #(
    parameter int unsigned NREQ = 32,
    localparam int unsigned IDW = $clog2(NREQ)
) (
    input  logic [NREQ-1:0] req_single,
    input  logic [NREQ-1:0] req_burst,
    input  logic [2:0]      mode,
    input  logic [IDW-1:0]  src_id,
    input  logic [IDW-1:0]  dst_id,
    output logic            go,
    output logic            mode_bad
);
    logic [NREQ-1:0] req_any;
    logic            src_hit;
    logic            dst_hit;

    always_comb begin
        req_any  = req_single | req_burst;
        src_hit  = req_any[src_id];
        dst_hit  = req_any[dst_id];
        mode_bad = mode[2];
        unique case (mode[1:0])
            2'd0:    go = 1'b1;
            2'd1:    go = dst_hit;
            2'd2:    go = src_hit;
            default: go = src_hit & dst_hit;
        endcase
        if (mode_bad) go = 1'b0;
    end
endmodule

// File: rtl/dma_elem_fmt.sv
`timescale 1ns/1ps
module dma_elem_fmt #(
    parameter int unsigned AW = 32
) (
    input  logic [2:0]    sw_log,
    input  logic [2:0]    dw_log,
    output logic [1:0]    size_log,
    output logic [AW-1:0] step,
    output logic          fmt_bad
);
    always_comb begin
        size_log = sw_log[1:0];
        step     = AW'(1) << sw_log[1:0];
        fmt_bad  = (sw_log != dw_log) || (sw_log > 3'd2);
    end
endmodule

// File: rtl/dma_chan_seq.sv
`timescale 1ns/1ps
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int unsigned NREQ = 32,
    localparam int unsigned IDW = $clog2(NREQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [NREQ-1:0]  req_single,
    input  logic [NREQ-1:0]  req_burst,
    output logic             mem_valid,
    output logic             mem_write,
    output logic [REG_W-1:0] mem_addr,
    output logic [1:0]       mem_size,
    output logic [REG_W-1:0] mem_wdata,
    input  logic             mem_ready,
    input  logic [REG_W-1:0] mem_rdata,
    output logic [REG_W-1:0] ch_src,
    output logic [REG_W-1:0] ch_dst,
    output logic [REG_W-1:0] ch_next,
    output logic [REG_W-1:0] ch_ctrl,
    output logic [REG_W-1:0] ch_conf,
    output logic             tc_pulse,
    output logic             err_flag
);
    seq_regs_t        q, d;
    logic             gate_go, mode_bad, fmt_bad;
    logic [1:0]       size_log;
    logic [REG_W-1:0] step;
    logic [CNT_W-1:0] cnt;
    logic             active;

    dma_req_gate #(.NREQ(NREQ)) u_gate (
        .req_single (req_single),
        .req_burst  (req_burst),
        .mode       (q.conf[CF_MODE +: 3]),
        .src_id     (q.conf[CF_SID +: IDW]),
        .dst_id     (q.conf[CF_DID +: IDW]),
        .go         (gate_go),
        .mode_bad   (mode_bad)
    );

    dma_elem_fmt #(.AW(REG_W)) u_fmt (
        .sw_log   (q.ctrl[CT_SW +: 3]),
        .dw_log   (q.ctrl[CT_DW +: 3]),
        .size_log (size_log),
        .step     (step),
        .fmt_bad  (fmt_bad)
    );

    always_comb begin
        d         = q;
        d.tc      = 1'b0;
        cnt       = q.ctrl[CNT_W-1:0];
        active    = q.conf[CF_EN] & ~q.conf[CF_HALT];
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = q.src;
        mem_size  = 2'd2;
        mem_wdata = q.data;

        unique case (q.st)
            ST_IDLE: begin
                if (active) begin
                    if (mode_bad || fmt_bad) d.err = 1'b1;
                    else if (cnt != '0 && gate_go) d.st = ST_RD;
                end
            end
            ST_RD: begin
                mem_valid = 1'b1;
                mem_size  = size_log;
                if (mem_ready) begin
                    d.data = mem_rdata;
                    if (q.ctrl[CT_SINC]) d.src = q.src + step;
                    d.st = ST_WR;
                end
            end
            ST_WR: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = q.dst;
                mem_size  = size_log;
                if (mem_ready) begin
                    if (q.ctrl[CT_DINC]) d.dst = q.dst + step;
                    d.ctrl[CNT_W-1:0] = cnt - 1'b1;
                    d.st = ST_IDLE;
                    if (cnt == CNT_W'(1)) begin
                        d.tc = q.ctrl[CT_TC];
                        if (q.nxt != '0) d.st = ST_FSRC;
                        else d.conf[CF_EN] = 1'b0;
                    end
                end
            end
            ST_FSRC: begin
                mem_valid = 1'b1;
                mem_addr  = q.nxt;
                if (mem_ready) begin
                    d.src = mem_rdata;
                    d.st  = ST_FDST;
                end
            end
            ST_FDST: begin
                mem_valid = 1'b1;
                mem_addr  = q.nxt + REG_W'(4);
                if (mem_ready) begin
                    d.dst = mem_rdata;
                    d.st  = ST_FCTL;
                end
            end
            ST_FCTL: begin
                mem_valid = 1'b1;
                mem_addr  = q.nxt + REG_W'(12);
                if (mem_ready) begin
                    d.ctrl = mem_rdata;
                    d.st   = ST_FNXT;
                end
            end
            ST_FNXT: begin
                mem_valid = 1'b1;
                mem_addr  = q.nxt + REG_W'(8);
                if (mem_ready) begin
                    d.nxt = mem_rdata;
                    d.st  = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (reg_we) begin
            d.err = 1'b0;
            unique case (reg_sel)
                3'd0:    d.src  = reg_wdata;
                3'd1:    d.dst  = reg_wdata;
                3'd2:    d.nxt  = reg_wdata;
                3'd3:    d.ctrl = reg_wdata;
                3'd4:    d.conf = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ch_src   = q.src;
    assign ch_dst   = q.dst;
    assign ch_next  = q.nxt;
    assign ch_ctrl  = q.ctrl;
    assign ch_conf  = q.conf;
    assign tc_pulse = q.tc;
    assign err_flag = q.err;
endmodule

// File: rtl/dma_chan_seq_chk.sv
`timescale 1ns/1ps
module dma_chan_seq_chk #(
    parameter int unsigned NREQ = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [2:0]       reg_sel,
    input logic [31:0]      reg_wdata,
    input logic [NREQ-1:0]  req_single,
    input logic [NREQ-1:0]  req_burst,
    input logic             mem_valid,
    input logic             mem_write,
    input logic [31:0]      mem_addr,
    input logic [1:0]       mem_size,
    input logic [31:0]      mem_wdata,
    input logic             mem_ready,
    input logic [31:0]      mem_rdata,
    input logic [31:0]      ch_src,
    input logic [31:0]      ch_dst,
    input logic [31:0]      ch_next,
    input logic [31:0]      ch_ctrl,
    input logic [31:0]      ch_conf,
    input logic             tc_pulse,
    input logic             err_flag
);
    logic [31:0] last_rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_rd_q <= '0;
        else if (mem_valid && !mem_write && mem_ready) last_rd_q <= mem_rdata;
    end

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

    p_wdata_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write |-> mem_wdata == last_rd_q);

    p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid && ch_conf[18] && !reg_we |=> !mem_valid);

    p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write && mem_ready && !reg_we |=>
        (ch_ctrl[11:0] == $past(ch_ctrl[11:0]) - 12'd1) && (ch_ctrl[31:12] == $past(ch_ctrl[31:12])));

    p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write && mem_ready && !reg_we && ch_ctrl[11:0] == 12'd1 && ch_next == 32'd0
        |=> !ch_conf[0]);

    p_tc_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);

    p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !mem_valid);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.NREQ(NREQ)) u_chk (.*);

// File: tb/dma_chan_seq_test.sv
`timescale 1ns/1ps
module dma_chan_seq_test;
    localparam int unsigned NREQ = 32;
    localparam logic [31:0] CTL_W4 = 32'h0C48_0000;  // width 4, both increments
    localparam logic [31:0] CTL_TC = 32'h8000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [NREQ-1:0] req_single = '0, req_burst = '0;
    logic mem_valid, mem_write, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0] mem_size;
    logic [31:0] ch_src, ch_dst, ch_next, ch_ctrl, ch_conf;
    logic tc_pulse, err_flag;

    int vectors = 0, miscompares = 0;
    logic [31:0] desc [0:7];
    logic [31:0] wr_addr [0:255], wr_data [0:255], rd_addr [0:255];
    logic [1:0]  wr_size [0:255];
    int wr_n = 0, rd_n = 0, tc_n = 0;
    logic [1:0] phase = '0;
    logic pend = 1'b0;
    logic [31:0] pend_addr = '0;

    always #5 clk = ~clk;

    dma_chan_seq #(.NREQ(NREQ)) uut (.*);

    function automatic logic [31:0] patt(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    always_comb begin
        if (mem_addr[31:5] == 27'h80) mem_rdata = desc[mem_addr[4:2]];
        else mem_rdata = patt(mem_addr);
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // memory model and monitors, all on the falling edge
    always @(negedge clk) begin
        if (pend && mem_addr != pend_addr) chk(0, "R12 address moved while stalled", mem_addr, pend_addr);
        phase <= phase + 2'd1;
        mem_ready = (phase != 2'd1);
        if (tc_pulse) tc_n++;
        pend      <= mem_valid && !mem_ready;
        pend_addr <= mem_addr;
        if (mem_valid && mem_ready) begin
            if (mem_write) begin
                wr_addr[wr_n[7:0]] = mem_addr;
                wr_data[wr_n[7:0]] = mem_wdata;
                wr_size[wr_n[7:0]] = mem_size;
                wr_n++;
            end else begin
                rd_addr[rd_n[7:0]] = mem_addr;
                rd_n++;
            end
        end
    end

    task automatic wreg(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] dd, input logic [31:0] n,
                         input logic [31:0] c, input logic [31:0] cf);
        wreg(3'd0, s); wreg(3'd1, dd); wreg(3'd2, n); wreg(3'd3, c); wreg(3'd4, cf);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_off();
        for (int i = 0; i < 2000 && ch_conf[0]; i++) @(negedge clk);
        idle(2);
    endtask

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int b, rb, tb;
        for (int i = 0; i < 8; i++) desc[i] = '0;
        idle(3);
        // R1: reset state
        chk(ch_src == 0 && ch_dst == 0 && ch_next == 0, "R1 address regs", ch_src | ch_dst | ch_next, 0);
        chk(ch_ctrl == 0 && ch_conf == 0, "R1 ctrl/conf", ch_ctrl | ch_conf, 0);
        chk(!mem_valid && !tc_pulse && !err_flag, "R1 outputs", {mem_valid, tc_pulse, err_flag}, 0);
        rst_n = 1'b1;
        idle(2);

        // R5 R6 R7 R9 R10: five word elements, both increments, no chain
        b = wr_n; tb = tc_n;
        setup(32'h100, 32'h300, 0, CTL_W4 | CTL_TC | 32'd5, 32'h1);
        wait_off();
        chk(wr_n - b == 5, "R5 element count", wr_n - b, 5);
        for (int k = 0; k < 5; k++) begin
            chk(wr_addr[b + k] == 32'h300 + 4 * k, "R6 dst step", wr_addr[b + k], 32'h300 + 4 * k);
            chk(wr_data[b + k] == patt(32'h100 + 4 * k), "R5 data", wr_data[b + k], patt(32'h100 + 4 * k));
            chk(wr_size[b + k] == 2'd2, "R5 size", {30'd0, wr_size[b + k]}, 2);
        end
        chk(ch_src == 32'h114 && ch_dst == 32'h314, "R6 final src", ch_src, 32'h114);
        chk(ch_ctrl == (CTL_W4 | CTL_TC), "R7 ctrl upper kept, count zero", ch_ctrl, CTL_W4 | CTL_TC);
        chk(ch_conf == 0, "R9 disabled at end", ch_conf, 0);
        chk(tc_n - tb == 1, "R10 one pulse", tc_n - tb, 1);

        // R5 R6: halfword width, no increments, no tc request
        b = wr_n; tb = tc_n;
        setup(32'h80, 32'h500, 0, 32'h0024_0003, 32'h1);
        wait_off();
        chk(wr_n - b == 3, "R5 halfword count", wr_n - b, 3);
        for (int k = 0; k < 3; k++) begin
            chk(wr_addr[b + k] == 32'h500, "R6 dst fixed", wr_addr[b + k], 32'h500);
            chk(wr_data[b + k] == patt(32'h80), "R6 src fixed", wr_data[b + k], patt(32'h80));
            chk(wr_size[b + k] == 2'd1, "R5 halfword size", {30'd0, wr_size[b + k]}, 1);
        end
        chk(tc_n - tb == 0, "R10 no pulse without bit 31", tc_n - tb, 0);

        // R2: disabled, then halted, then released
        b = wr_n;
        setup(32'h100, 32'h300, 0, CTL_W4 | 32'd1, 32'h0);
        idle(20);
        chk(wr_n == b, "R2 disabled no transfer", wr_n - b, 0);
        wreg(3'd4, 32'h0004_0001);
        idle(20);
        chk(wr_n == b && !mem_valid, "R2 halted no transfer", wr_n - b, 0);
        wreg(3'd4, 32'h1);
        idle(20);
        chk(wr_n - b == 1, "R2 release transfers", wr_n - b, 1);

        // R4: zero count
        b = wr_n;
        setup(32'h100, 32'h300, 0, CTL_W4, 32'h1);
        idle(20);
        chk(wr_n == b, "R4 zero count no transfer", wr_n - b, 0);
        chk(ch_conf == 32'h1, "R4 stays enabled", ch_conf, 1);
        wreg(3'd4, 0);

        // R3: flow gate sweep, src ID 3 and dst ID 17, over single and burst lines
        for (int m = 0; m < 4; m++) begin
            for (int via = 0; via < 2; via++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [31:0] rq;
                    bit exp_go;
                    rq = (p[0] ? 32'h8 : 32'h0) | (p[1] ? 32'h2_0000 : 32'h0);
                    exp_go = (m == 0) || (m == 1 && p[1]) || (m == 2 && p[0]) || (m == 3 && p == 3);
                    @(negedge clk);
                    if (via == 0) req_single = rq; else req_burst = rq;
                    b = wr_n;
                    setup(32'h100, 32'h300, 0, CTL_W4 | 32'd1,
                          32'h1 | (32'(m) << 11) | (32'd3 << 1) | (32'd17 << 6));
                    idle(20);
                    chk((wr_n - b) == int'(exp_go), $sformatf("R3 mode %0d req %0d via %0d", m, p, via),
                        wr_n - b, {31'd0, exp_go});
                    wreg(3'd4, 0);
                    req_single = '0; req_burst = '0;
                end
            end
        end

        // R8 R10: two-descriptor chain
        desc[0] = 32'h600; desc[1] = 32'h800; desc[2] = 32'h1010; desc[3] = CTL_W4 | 32'd3;
        desc[4] = 32'hA00; desc[5] = 32'hC00; desc[6] = 32'h0;    desc[7] = CTL_W4 | CTL_TC | 32'd1;
        b = wr_n; rb = rd_n; tb = tc_n;
        setup(32'h200, 32'h400, 32'h1000, CTL_W4 | CTL_TC | 32'd2, 32'h1);
        wait_off();
        chk(wr_n - b == 6, "R8 chained element count", wr_n - b, 6);
        chk(rd_addr[rb + 2] == 32'h1000 && rd_addr[rb + 3] == 32'h1004, "R8 fetch order a", rd_addr[rb + 3], 32'h1004);
        chk(rd_addr[rb + 4] == 32'h100C && rd_addr[rb + 5] == 32'h1008, "R8 fetch order b", rd_addr[rb + 5], 32'h1008);
        chk(rd_addr[rb + 9] == 32'h1010 && rd_addr[rb + 11] == 32'h101C, "R8 second fetch", rd_addr[rb + 11], 32'h101C);
        chk(wr_addr[b + 2] == 32'h800 && wr_data[b + 4] == patt(32'h608), "R8 second block", wr_data[b + 4], patt(32'h608));
        chk(wr_addr[b + 5] == 32'hC00 && wr_data[b + 5] == patt(32'hA00), "R8 third block", wr_data[b + 5], patt(32'hA00));
        chk(ch_src == 32'hA04 && ch_dst == 32'hC04 && ch_next == 0, "R8 final regs", ch_src, 32'hA04);
        chk(tc_n - tb == 2, "R10 pulses across chain", tc_n - tb, 2);

        // R11: bad mode and bad format
        b = wr_n;
        setup(32'h100, 32'h300, 0, CTL_W4 | 32'd1, 32'h1 | (32'd5 << 11));
        idle(5);
        chk(err_flag && wr_n == b, "R11 mode 5 error", {31'd0, err_flag}, 1);
        wreg(3'd4, 0);
        idle(2);
        chk(!err_flag, "R11 cleared by write", {31'd0, err_flag}, 0);
        setup(32'h100, 32'h300, 0, 32'h0C08_0001, 32'h1);
        idle(5);
        chk(err_flag && wr_n == b, "R11 width mismatch error", {31'd0, err_flag}, 1);
        wreg(3'd4, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule